// File: doc/BRIEF.md
# SDRAM Full-Page Read Burst Sequencer

This block runs one fixed-length read burst from bank 0 of a 16-bit SDR SDRAM on behalf of a controller state machine. While the controller holds `en` high, the sequencer drives the SDRAM command bus through a lead-in NOP, a row ACTIVE, the row-to-column wait, a READ in full-page mode and a stop command. The stop command is timed so that exactly `BURST_LEN` words come back. The block captures each word from the data bus after the CAS latency, presents it with a valid strobe, and pulses `done` when the last word arrives.

The controller moves to a refresh state as soon as it sees `done`, so it drops `en` at that point. If `en` stays high after `done`, the sequencer waits and does not start a second burst. Dropping `en` at any point aborts the burst, and the bus returns to its quiet state on the next cycle. The row and column addresses are taken once, on the cycle the burst starts.

Top module: `sdram_page_reader`

## Requirements
- R1: While reset is active, and on each cycle after a cycle in which `en` was sampled low, the bus is quiet: `sd_cke`=1, `sd_cmd`=NOP (4'b0111 as {CS#,RAS#,CAS#,WE#}), `sd_ba`=0, `sd_addr`=0, every `sd_dqm` bit is 1, and `rd_valid` and `done` are 0.
- R2: On the first cycle after `en` is sampled high from the quiet state, the command is NOP. ACTIVE (4'b0011) to bank 0 follows in the next cycle, which is the second cycle after the `en` edge.
- R3: READ (4'b0101) is issued exactly 3 cycles after ACTIVE, with NOPs in the two cycles between. Its address carries the column in the low bits, and A10 and all higher bits are 0, so there is no auto-precharge.
- R4: BURST TERMINATE (4'b0110) is issued exactly once per burst, `BURST_LEN` cycles after READ. No other ACTIVE or READ is issued in the same burst.
- R5: `rd_valid` is high for exactly `BURST_LEN` cycles per burst. Word i is the value on `sd_dq_in` at the (CAS_LAT+i)-th rising edge after the edge that samples READ, and `rd_data` shows it in the cycle after that edge.
- R6: `done` is high for exactly one cycle. That cycle is the cycle of the last valid word, which is CAS_LAT+BURST_LEN cycles after the READ cycle.
- R7: `sd_dqm` is all zeros from the READ cycle through the cycle whose ending edge captures the last word. It is all ones on the ACTIVE cycle and on the `done` cycle.
- R8: If `en` stays high after `done`, no new ACTIVE is issued and the bus stays NOP. A new burst needs `en` low and then high again.
- R9: Dropping `en` in the middle of a burst gives a quiet bus on the next cycle. After that, no further word, stop command or `done` appears.
- R10: The row and column are latched on the cycle the burst starts. Changing `row_addr` or `col_addr` later in the burst has no effect on the ACTIVE or READ address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Burst enable from the controller state machine |
| row_addr | input | ROW_W (13) | Row to open |
| col_addr | input | COL_W (10) | Starting column |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cmd | output | 4 | {CS#,RAS#,CAS#,WE#} command |
| sd_dqm | output | DATA_W/8 (2) | Byte masks, active high |
| sd_ba | output | BANK_W (2) | Bank address, always 0 |
| sd_addr | output | ADDR_W (13) | Multiplexed row/column address |
| sd_dq_in | input | DATA_W (16) | Read data from the SDRAM |
| rd_data | output | DATA_W (16) | Captured word |
| rd_valid | output | 1 | `rd_data` holds a burst word this cycle |
| done | output | 1 | One-cycle pulse on the last word |

## Verification
If the burst counter is off by even one count, the stop command moves by a cycle. The number of valid words then changes, and the `done` pulse shifts away from the last word. This shows at the ports about 600 cycles after READ, and the bench compares every cycle stamp against arithmetic from the READ cycle. A fault in the state order shows within a few cycles of `en` as a missing NOP, a wrong ACTIVE-to-READ gap or a second ACTIVE. A fault in the capture path shows as the first data word failing to match the responder's pattern.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    // {CS#, RAS#, CAS#, WE#}
    typedef enum logic [3:0] {
        CMD_PRE  = 4'b0010,
        CMD_ACT  = 4'b0011,
        CMD_READ = 4'b0101,
        CMD_BST  = 4'b0110,
        CMD_NOP  = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_ACT,
        ST_RCD,
        ST_RDCMD,
        ST_STREAM,
        ST_FIN,
        ST_HOLD
    } seq_state_e;

    typedef enum logic [1:0] {
        ADDR_NONE,
        ADDR_ROW,
        ADDR_COL
    } addr_src_e;

    typedef struct packed {
        logic      cke;
        sd_cmd_e   cmd;
        logic      mask;
        addr_src_e src;
        logic      done;
    } bus_ctl_t;

    // Bus controls as a function of the sequencer state.
    function automatic bus_ctl_t ctl_of(seq_state_e st, logic at_stop, sd_cmd_e stop_cmd);
        bus_ctl_t c;
        c.cke  = 1'b1;
        c.cmd  = CMD_NOP;
        c.mask = 1'b1;
        c.src  = ADDR_NONE;
        c.done = 1'b0;
        case (st)
            ST_ACT: begin
                c.cmd = CMD_ACT;
                c.src = ADDR_ROW;
            end
            ST_RDCMD: begin
                c.cmd  = CMD_READ;
                c.src  = ADDR_COL;
                c.mask = 1'b0;
            end
            ST_STREAM: begin
                c.mask = 1'b0;
                if (at_stop) c.cmd = stop_cmd;
            end
            ST_FIN: c.done = 1'b1;
            default: ;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/sdr_rd_seq.sv
module sdr_rd_seq
    import sdr_rd_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int CNT_W     = 10,
    parameter int BURST_LEN = 600,
    parameter int CAS_LAT   = 3,
    parameter int RCD_NOPS  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ROW_W-1:0] row_in,
    input  logic [COL_W-1:0] col_in,
    output seq_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output logic [ROW_W-1:0] row_q,
    output logic [COL_W-1:0] col_q,
    output logic             take
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(BURST_LEN + CAS_LAT - 1);
    localparam logic [CNT_W-1:0] RCD_C  = CNT_W'(RCD_NOPS);
    localparam logic [CNT_W-1:0] CL_C   = CNT_W'(CAS_LAT);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    seq_state_e       nxt;
    logic [CNT_W-1:0] cnt_n;

    always_comb begin
        nxt   = state;
        cnt_n = cnt;
        if (!en) begin
            nxt   = ST_IDLE;
            cnt_n = '0;
        end else begin
            case (state)
                ST_IDLE:  nxt = ST_LEAD;
                ST_LEAD:  nxt = ST_ACT;
                ST_ACT: begin
                    nxt   = ST_RCD;
                    cnt_n = ONE_C;
                end
                ST_RCD: begin
                    if (cnt == RCD_C) begin
                        nxt   = ST_RDCMD;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + ONE_C;
                    end
                end
                ST_RDCMD: begin
                    nxt   = ST_STREAM;
                    cnt_n = ONE_C;
                end
                ST_STREAM: begin
                    if (cnt == LAST_C) begin
                        nxt   = ST_FIN;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + ONE_C;
                    end
                end
                ST_FIN:  nxt = ST_HOLD;
                default: nxt = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            row_q <= '0;
            col_q <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_n;
            if (state == ST_IDLE && en) begin
                row_q <= row_in;
                col_q <= col_in;
            end
        end
    end

    assign take = en && (state == ST_STREAM) && (cnt >= CL_C);
endmodule

// File: rtl/sdr_rd_cmd_enc.sv
module sdr_rd_cmd_enc
    import sdr_rd_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int ADDR_W    = 13,
    parameter int BANK_W    = 2,
    parameter int DQM_W     = 2,
    parameter int CNT_W     = 10,
    parameter int BURST_LEN = 600,
    parameter bit USE_PRE   = 1'b0
) (
    input  seq_state_e        state,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [ROW_W-1:0]  row_q,
    input  logic [COL_W-1:0]  col_q,
    output logic              cke,
    output logic [3:0]        cmd,
    output logic [DQM_W-1:0]  dqm,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [CNT_W-1:0] STOP_AT = CNT_W'(BURST_LEN);
    localparam sd_cmd_e STOP_CMD = USE_PRE ? CMD_PRE : CMD_BST;

    bus_ctl_t ctl;

    always_comb begin
        ctl  = ctl_of(state, cnt == STOP_AT, STOP_CMD);
        cke  = ctl.cke;
        cmd  = ctl.cmd;
        dqm  = {DQM_W{ctl.mask}};
        done = ctl.done;
        ba   = '0;
        addr = '0;
        case (ctl.src)
            ADDR_ROW: addr[ROW_W-1:0] = row_q;
            ADDR_COL: addr[COL_W-1:0] = col_q;
            default:  ;
        endcase
    end
endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] data,
    output logic              valid
);
    timeunit 1ns;
    timeprecision 100ps;

    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= take;
            if (take) data <= dq_in;
        end
    end
endmodule

// File: rtl/sdram_page_reader.sv
module sdram_page_reader
    import sdr_rd_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int ADDR_W    = 13,
    parameter int BANK_W    = 2,
    parameter int DATA_W    = 16,
    parameter int BURST_LEN = 600,
    parameter int CAS_LAT   = 3,
    parameter int RCD_NOPS  = 2,
    parameter bit USE_PRE   = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [ROW_W-1:0]    row_addr,
    input  logic [COL_W-1:0]    col_addr,
    output logic                sd_cke,
    output logic [3:0]          sd_cmd,
    output logic [DATA_W/8-1:0] sd_dqm,
    output logic [BANK_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0]   sd_addr,
    input  logic [DATA_W-1:0]   sd_dq_in,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_valid,
    output logic                done
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DQM_W = DATA_W / 8;
    localparam int CNT_W = $clog2(BURST_LEN + CAS_LAT + 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             take;

    sdr_rd_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W),
        .BURST_LEN(BURST_LEN), .CAS_LAT(CAS_LAT), .RCD_NOPS(RCD_NOPS)
    ) u_seq (
        .clk(clk), .rst(rst), .en(en),
        .row_in(row_addr), .col_in(col_addr),
        .state(state), .cnt(cnt), .row_q(row_q), .col_q(col_q), .take(take)
    );

    sdr_rd_cmd_enc #(
        .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W),
        .DQM_W(DQM_W), .CNT_W(CNT_W), .BURST_LEN(BURST_LEN), .USE_PRE(USE_PRE)
    ) u_enc (
        .state(state), .cnt(cnt), .row_q(row_q), .col_q(col_q),
        .cke(sd_cke), .cmd(sd_cmd), .dqm(sd_dqm), .ba(sd_ba),
        .addr(sd_addr), .done(done)
    );

    sdr_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst(rst), .take(take), .dq_in(sd_dq_in),
        .data(rd_data), .valid(rd_valid)
    );
endmodule

// File: rtl/sdr_rd_checker.sv
module sdr_rd_checker
    import sdr_rd_pkg::*;
#(
    parameter int DQM_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [3:0]       cmd,
    input logic [DQM_W-1:0] dqm,
    input logic             done,
    input logic             rd_valid
);
    timeunit 1ns;
    timeprecision 100ps;

    assert_idle_bus_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> (cmd == CMD_NOP && dqm == {DQM_W{1'b1}} && !done));

    assert_rcd_gap_R3: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_READ |-> ($past(cmd, 3) == CMD_ACT && $past(cmd, 2) == CMD_NOP
                             && $past(cmd, 1) == CMD_NOP));

    assert_read_unmasked_R7: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_READ |-> dqm == '0);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_last_word_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> rd_valid);

    assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> !rd_valid);
endmodule

bind sdram_page_reader sdr_rd_checker #(.DQM_W(DATA_W / 8)) u_chk (
    .clk(clk), .rst(rst), .en(en), .cmd(sd_cmd), .dqm(sd_dqm),
    .done(done), .rd_valid(rd_valid)
);

// File: tb/sim_sdram_page_reader.sv
module sim_sdram_page_reader;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int B  = 600;
    localparam int CL = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [12:0] row_addr = '0;
    logic [9:0]  col_addr = '0;
    logic        sd_cke;
    logic [3:0]  sd_cmd;
    logic [1:0]  sd_dqm;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic [15:0] sd_dq_in = 16'hDEAD;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        done;

    sdram_page_reader u0 (
        .clk(clk), .rst(rst), .en(en), .row_addr(row_addr), .col_addr(col_addr),
        .sd_cke(sd_cke), .sd_cmd(sd_cmd), .sd_dqm(sd_dqm), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_dq_in(sd_dq_in), .rd_data(rd_data),
        .rd_valid(rd_valid), .done(done)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad_chk = 0;
    bit finished = 1'b0;

    // Monitor / responder state (cleared per burst)
    int n_act, a_cyc, n_rd, r_cyc, n_bst, b_cyc, n_done, d_cyc;
    int n_valid, n_bad, last_v, dqm_bad, row_seen, col_seen;
    int dqm_act, dqm_done, bad_ba, exp_row, exp_col;

    function automatic logic [15:0] pat(int r, int c, int i);
        return 16'((r * 7) + (c * 3) + i * 5 + 16'h1111);
    endfunction

    task automatic clear_mon();
        n_act = 0; n_rd = 0; n_bst = 0; n_done = 0; n_valid = 0; n_bad = 0;
        dqm_bad = 0; bad_ba = 0; a_cyc = -1; r_cyc = -1; b_cyc = -1; d_cyc = -1;
        last_v = -1; row_seen = -1; col_seen = -1; dqm_act = -1; dqm_done = -1;
    endtask

    // Everything sampled at the falling edge; dq driven there for the next rise.
    always @(negedge clk) begin
        if (!rst) begin
            case (sd_cmd)
                4'b0011: begin n_act++; a_cyc = cyc; row_seen = int'(sd_addr); dqm_act = int'(sd_dqm); end
                4'b0101: begin n_rd++; r_cyc = cyc; col_seen = int'(sd_addr); end
                4'b0110: begin n_bst++; b_cyc = cyc; end
                default: ;
            endcase
            if (sd_ba != 2'd0) bad_ba++;
            sd_dq_in = 16'hDEAD;
            if (n_rd > 0 && cyc >= r_cyc + CL && (n_bst == 0 || cyc <= b_cyc + CL - 1))
                sd_dq_in = pat(row_seen, col_seen, cyc - r_cyc - CL);
            if (n_rd > 0 && cyc >= r_cyc && cyc <= r_cyc + CL + B - 1 && sd_dqm != 2'b00)
                dqm_bad++;
            if (rd_valid) begin
                if (rd_data != pat(exp_row, exp_col, n_valid)) n_bad++;
                n_valid++;
                last_v = cyc;
            end
            if (done) begin n_done++; d_cyc = cyc; dqm_done = int'(sd_dqm); end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad_chk++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_quiet(string req);
        chk(sd_cke == 1'b1 && sd_cmd == 4'b0111 && sd_ba == 2'd0 && sd_addr == 13'd0
            && sd_dqm == 2'b11 && !rd_valid && !done, req,
            int'({sd_cke, sd_cmd, sd_dqm, rd_valid, done}), int'(9'b1_0111_11_00));
    endtask

    task automatic run_burst(int row, int col, bit hold);
        int e0;
        @(posedge clk); clear_mon();
        @(negedge clk);
        row_addr = 13'(row); col_addr = 10'(col); exp_row = row; exp_col = col;
        en = 1'b1; e0 = cyc;
        @(negedge clk);
        chk(sd_cmd == 4'b0111 && n_act == 0, "R2 lead-in NOP", int'(sd_cmd), 7);
        row_addr = ~row_addr; col_addr = ~col_addr;   // R10: late changes ignored
        for (int k = 0; k < 3000 && n_done == 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(n_act == 1 && a_cyc == e0 + 2 && bad_ba == 0, "R2 ACTIVE cycle", a_cyc - e0, 2);
        chk(row_seen == row, "R10 latched row", row_seen, row);
        chk(n_rd == 1 && r_cyc == a_cyc + 3, "R3 ACTIVE-to-READ gap", r_cyc - a_cyc, 3);
        chk(col_seen == col, "R3/R10 READ address col, A10 clear", col_seen, col);
        chk(n_bst == 1 && b_cyc == r_cyc + B, "R4 stop timing", b_cyc - r_cyc, B);
        chk(n_valid == B, "R5 word count", n_valid, B);
        chk(n_bad == 0, "R5 word data", n_bad, 0);
        chk(n_done == 1 && d_cyc == r_cyc + CL + B, "R6 done cycle", d_cyc - r_cyc, CL + B);
        chk(last_v == d_cyc, "R6 done on last word", last_v, d_cyc);
        chk(dqm_bad == 0 && dqm_act == 3 && dqm_done == 3, "R7 DQM window", dqm_bad, 0);
        if (hold) begin
            repeat (20) @(negedge clk);
            chk(n_act == 1 && sd_cmd == 4'b0111 && !rd_valid, "R8 no rerun while en held", n_act, 1);
        end
        en = 1'b0;
        @(negedge clk);
        chk_quiet("R1 quiet after en low");
    endtask

    task automatic run_abort(int words);
        int nv;
        @(posedge clk); clear_mon();
        @(negedge clk);
        row_addr = 13'd77; col_addr = 10'd5; exp_row = 77; exp_col = 5; en = 1'b1;
        for (int k = 0; k < 3000 && n_valid < words; k++) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk_quiet("R9 quiet cycle after abort");
        nv = n_valid;
        repeat (CL + B + 10) @(negedge clk);
        chk(n_valid == nv && n_done == 0 && n_bst == 0 && n_bad == 0,
            "R9 nothing after abort", n_valid + n_done * 1000 + n_bst * 100, nv);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk_quiet("R1 reset state");
        rst = 1'b0;
        @(negedge clk);
        chk_quiet("R1 idle after reset");
        run_burst(0, 0, 1'b0);
        run_burst(13'h1FFF, 10'h3FF, 1'b1);
        run_burst(13'h0A5A, 10'h155, 1'b0);
        run_burst(13'h1234, 10'h0FF, 1'b0);
        run_abort(40);
        // abort right after start: no ACTIVE must follow
        @(posedge clk); clear_mon();
        @(negedge clk); en = 1'b1;
        @(negedge clk); en = 1'b0;
        repeat (6) @(negedge clk);
        chk(n_act == 0 && n_rd == 0, "R9 abort in lead-in", n_act, 0);
        run_burst(13'h0555, 10'h2AA, 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad_chk, n_chk);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad_chk, n_chk);
            $finish;
        end
    end
endmodule